// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block drives program-counter updates for the jump, call and return instructions of a 32-bit processor with byte-addressed memory. The decoder hands it a one-cycle start strobe with a 3-bit operation code, the raw instruction field bits, an extension word, the address of the instruction, the stack pointer and the four address registers. It then works out the destination and produces a single-cycle program-counter write.

Calls also save a link address. The link is the instruction address plus that form's encoded length. It goes to the stack as four byte writes, lowest byte at the stack pointer. The same value is written to a dedicated multiply/divide register through a separate write strobe. A return reads four bytes from the stack through a read port with one cycle of latency and assembles them into the new program counter. The stack pointer itself is never modified here. While a sequence runs, the block reports busy and ignores new requests.

Top module: `branch_link_seq`

## Requirements
- R1: Operation code 0 (register jump) loads the program counter with the address register chosen by field bits [1:0]. The other field bits are ignored. `pc_we_o` pulses in the cycle after acceptance.
- R2: Operation code 1 (short relative jump) targets the instruction address plus field bits [15:0] sign-extended, wrapping modulo 2^32. `pc_we_o` pulses in the cycle after acceptance.
- R3: Operation code 2 (long relative jump) targets the instruction address plus the 32-bit value {field[23:0], ext[7:0]}. `pc_we_o` pulses in the cycle after acceptance.
- R4: Call targets are formed as follows. Code 3 uses the address register chosen by field[1:0]. Code 4 uses the instruction address plus sign-extended field[15:0]. Code 5 uses the instruction address plus {field[15:0], ext[15:0]}.
- R5: A call's link address is the instruction address plus 2 (code 3), 4 (code 4) or 6 (code 5). `mdr_we_o` pulses with `mdr_o` equal to the link, in the same cycle as `pc_we_o`.
- R6: A call writes to memory on the four cycles after acceptance. The addresses are SP, SP+1, SP+2 and SP+3 modulo 2^32, carrying link bits [7:0], [15:8], [23:16] and [31:24] in that order. `pc_we_o` follows in the next cycle.
- R7: Operation code 6 (return) reads SP..SP+3 on the four cycles after acceptance. Each byte is expected one cycle after its address. Two cycles after the last read, `pc_we_o` pulses with the little-endian word read. `mdr_we_o` stays low.
- R8: `busy_o` is high from the cycle after acceptance through the `pc_we_o` cycle, and low in the following cycle. No memory or register strobe is active while `busy_o` is low.
- R9: A start strobe arriving while busy is ignored. The running sequence completes with its own values.
- R10: Operation code 7 is not accepted. `busy_o` stays low and no strobe follows.
- R11: During and right after reset, `busy_o`, `pc_we_o`, `mdr_we_o`, `mem_we_o` and `mem_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when idle |
| op_i | input | 3 | Operation code |
| field_i | input | 24 | Instruction field bits |
| ext_i | input | 16 | Instruction extension word |
| pc_i | input | 32 | Address of the instruction |
| sp_i | input | 32 | Stack pointer |
| areg_i | input | 128 | Address registers, register n at bits [32n+31:32n] |
| busy_o | output | 1 | Sequence in progress |
| pc_we_o | output | 1 | Program-counter write strobe |
| pc_o | output | 32 | New program counter |
| mdr_we_o | output | 1 | Multiply/divide register write strobe |
| mdr_o | output | 32 | Link address for that register |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_waddr_o | output | 32 | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| mem_re_o | output | 1 | Stack byte read strobe |
| mem_raddr_o | output | 32 | Stack byte read address |
| mem_rdata_i | input | 8 | Read byte, valid one cycle after the address |

## Verification
The bench sweeps every address-register selector and a set of short displacements around the sign boundary (0x7fff, 0x8000, 0xffff). A sign-extension or field-position fault would show up as a wrong target. Instruction addresses near 2^32 and a stack pointer at 0xFFFFFFFE exercise wrap of both target and byte address. An unwrapped adder would write or read the wrong byte. After each call, a return from the same stack pointer must reproduce the link. A byte-order or read-latency error would give back a rotated or shifted word. A request injected mid-call and an unused operation code must leave the sequence and the outputs unchanged.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [2:0] {
    OP_JMP_REG  = 3'd0,
    OP_JMP_D16  = 3'd1,
    OP_JMP_D32  = 3'd2,
    OP_CALL_REG = 3'd3,
    OP_CALL_D16 = 3'd4,
    OP_CALL_D32 = 3'd5,
    OP_RET      = 3'd6,
    OP_NONE     = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP,
    ST_DRAIN,
    ST_DONE
  } state_e;

  // encoded length of each call form, added to form the link address
  localparam int unsigned LEN_CALL_REG = 2;
  localparam int unsigned LEN_CALL_D16 = 4;
  localparam int unsigned LEN_CALL_D32 = 6;

  function automatic logic op_is_call(op_e o);
    return (o == OP_CALL_REG) || (o == OP_CALL_D16) || (o == OP_CALL_D32);
  endfunction

  function automatic logic op_is_ret(op_e o);
    return o == OP_RET;
  endfunction

  function automatic logic op_is_legal(op_e o);
    return o != OP_NONE;
  endfunction

endpackage

// File: rtl/bls_target.sv
module bls_target
  import bls_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_AREG = 4,
  parameter int SEL_W    = 2
) (
  input  op_e                    op_i,
  input  logic [23:0]            field_i,
  input  logic [15:0]            ext_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [NUM_AREG*XLEN-1:0] areg_i,
  output logic [XLEN-1:0]        target_o,
  output logic [XLEN-1:0]        link_o
);

  logic [XLEN-1:0] areg_arr [NUM_AREG];

  for (genvar g = 0; g < NUM_AREG; g++) begin : g_areg
    assign areg_arr[g] = areg_i[g*XLEN +: XLEN];
  end

  logic [SEL_W-1:0] sel;
  logic [XLEN-1:0]  disp16;
  logic [XLEN-1:0]  disp_jmp_long;
  logic [XLEN-1:0]  disp_call_long;

  assign sel            = field_i[SEL_W-1:0];
  assign disp16         = {{(XLEN-16){field_i[15]}}, field_i[15:0]};
  assign disp_jmp_long  = XLEN'({field_i[23:0], ext_i[7:0]});
  assign disp_call_long = XLEN'({field_i[15:0], ext_i[15:0]});

  always_comb begin
    unique case (op_i)
      OP_JMP_REG, OP_CALL_REG: target_o = areg_arr[sel];
      OP_JMP_D16, OP_CALL_D16: target_o = pc_i + disp16;
      OP_JMP_D32:              target_o = pc_i + disp_jmp_long;
      OP_CALL_D32:             target_o = pc_i + disp_call_long;
      default:                 target_o = '0;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_CALL_REG: link_o = pc_i + XLEN'(LEN_CALL_REG);
      OP_CALL_D16: link_o = pc_i + XLEN'(LEN_CALL_D16);
      OP_CALL_D32: link_o = pc_i + XLEN'(LEN_CALL_D32);
      default:     link_o = pc_i;
    endcase
  end

endmodule

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_e              op_i,
  output logic             accept_o,
  output state_e           state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             is_call_o,
  output logic             is_ret_o
);

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic             is_call_q;
  logic             is_ret_q;
  logic             last_byte;

  assign accept_o  = start_i && (state_q == ST_IDLE) && op_is_legal(op_i);
  assign last_byte = (idx_q == IDX_W'(BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      is_call_q <= 1'b0;
      is_ret_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            idx_q     <= '0;
            is_call_q <= op_is_call(op_i);
            is_ret_q  <= op_is_ret(op_i);
            if (op_is_call(op_i))     state_q <= ST_PUSH;
            else if (op_is_ret(op_i)) state_q <= ST_POP;
            else                      state_q <= ST_DONE;
          end
        end
        ST_PUSH: begin
          idx_q <= idx_q + 1'b1;
          if (last_byte) state_q <= ST_DONE;
        end
        ST_POP: begin
          idx_q <= idx_q + 1'b1;
          if (last_byte) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign idx_o     = idx_q;
  assign is_call_o = is_call_q;
  assign is_ret_o  = is_ret_q;

endmodule

// File: rtl/bls_stack_lane.sv
module bls_stack_lane
  import bls_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int BYTES = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  state_e           state_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  link_i,
  output logic             we_o,
  output logic [XLEN-1:0]  waddr_o,
  output logic [7:0]       wdata_o,
  output logic             re_o,
  output logic [XLEN-1:0]  raddr_o,
  input  logic [7:0]       rdata_i,
  output logic [XLEN-1:0]  word_o
);

  logic [7:0]       link_b [BYTES];
  logic [7:0]       rd_b_q [BYTES];
  logic [XLEN-1:0]  addr;
  logic             rd_pend_q;
  logic [IDX_W-1:0] rd_idx_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign link_b[g]       = link_i[8*g +: 8];
    assign word_o[8*g +: 8] = rd_b_q[g];
  end

  // byte address wraps modulo 2^XLEN
  assign addr    = sp_i + XLEN'(idx_i);
  assign we_o    = (state_i == ST_PUSH);
  assign waddr_o = addr;
  assign wdata_o = link_b[idx_i];
  assign re_o    = (state_i == ST_POP);
  assign raddr_o = addr;

  // read data lags its address by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_idx_q  <= '0;
      for (int i = 0; i < BYTES; i++) rd_b_q[i] <= '0;
    end else begin
      rd_pend_q <= re_o;
      rd_idx_q  <= idx_i;
      if (rd_pend_q) rd_b_q[rd_idx_q] <= rdata_i;
    end
  end

endmodule

// File: rtl/branch_link_seq.sv
module branch_link_seq
  import bls_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_AREG = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [2:0]               op_i,
  input  logic [23:0]              field_i,
  input  logic [15:0]              ext_i,
  input  logic [XLEN-1:0]          pc_i,
  input  logic [XLEN-1:0]          sp_i,
  input  logic [NUM_AREG*XLEN-1:0] areg_i,
  output logic                     busy_o,
  output logic                     pc_we_o,
  output logic [XLEN-1:0]          pc_o,
  output logic                     mdr_we_o,
  output logic [XLEN-1:0]          mdr_o,
  output logic                     mem_we_o,
  output logic [XLEN-1:0]          mem_waddr_o,
  output logic [7:0]               mem_wdata_o,
  output logic                     mem_re_o,
  output logic [XLEN-1:0]          mem_raddr_o,
  input  logic [7:0]               mem_rdata_i
);

  localparam int BYTES = XLEN / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam int SEL_W = $clog2(NUM_AREG);

  op_e              op;
  logic             accept;
  state_e           state;
  logic [IDX_W-1:0] idx;
  logic             is_call;
  logic             is_ret;
  logic [XLEN-1:0]  target;
  logic [XLEN-1:0]  link;
  logic [XLEN-1:0]  target_q;
  logic [XLEN-1:0]  link_q;
  logic [XLEN-1:0]  sp_q;
  logic [XLEN-1:0]  word;

  assign op = op_e'(op_i);

  bls_target #(
    .XLEN    (XLEN),
    .NUM_AREG(NUM_AREG),
    .SEL_W   (SEL_W)
  ) i_target (
    .op_i    (op),
    .field_i (field_i),
    .ext_i   (ext_i),
    .pc_i    (pc_i),
    .areg_i  (areg_i),
    .target_o(target),
    .link_o  (link)
  );

  bls_ctrl #(
    .BYTES(BYTES),
    .IDX_W(IDX_W)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op),
    .accept_o (accept),
    .state_o  (state),
    .idx_o    (idx),
    .is_call_o(is_call),
    .is_ret_o (is_ret)
  );

  // operands captured once so later input changes cannot disturb a sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      link_q   <= '0;
      sp_q     <= '0;
    end else if (accept) begin
      target_q <= target;
      link_q   <= link;
      sp_q     <= sp_i;
    end
  end

  bls_stack_lane #(
    .XLEN (XLEN),
    .BYTES(BYTES),
    .IDX_W(IDX_W)
  ) i_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .idx_i  (idx),
    .sp_i   (sp_q),
    .link_i (link_q),
    .we_o   (mem_we_o),
    .waddr_o(mem_waddr_o),
    .wdata_o(mem_wdata_o),
    .re_o   (mem_re_o),
    .raddr_o(mem_raddr_o),
    .rdata_i(mem_rdata_i),
    .word_o (word)
  );

  assign busy_o   = (state != ST_IDLE);
  assign pc_we_o  = (state == ST_DONE);
  assign pc_o     = is_ret ? word : target_q;
  assign mdr_we_o = (state == ST_DONE) && is_call;
  assign mdr_o    = link_q;

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [2:0]      op_i,
  input logic            busy_o,
  input logic            pc_we_o,
  input logic            mdr_we_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_waddr_o,
  input logic            mem_re_o,
  input logic [XLEN-1:0] mem_raddr_o
);

  a_r6_push_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_waddr_o == $past(mem_waddr_o) + 1'b1));

  a_r7_pop_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_raddr_o == $past(mem_raddr_o) + 1'b1));

  a_r6_push_then_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_o) |-> pc_we_o);

  a_r6_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_re_o);

  a_r5_mdr_with_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdr_we_o |-> pc_we_o);

  a_r8_strobe_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o || pc_we_o || mdr_we_o) |-> busy_o);

  a_r8_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> (!busy_o && !pc_we_o));

  a_r10_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 3'd7) |=> !busy_o);

endmodule

bind branch_link_seq bls_checker #(.XLEN(XLEN)) i_bls_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .op_i       (op_i),
  .busy_o     (busy_o),
  .pc_we_o    (pc_we_o),
  .mdr_we_o   (mdr_we_o),
  .mem_we_o   (mem_we_o),
  .mem_waddr_o(mem_waddr_o),
  .mem_re_o   (mem_re_o),
  .mem_raddr_o(mem_raddr_o)
);

// File: tb/test_branch_link_seq.sv
module test_branch_link_seq;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         start;
  logic [2:0]   op;
  logic [23:0]  field;
  logic [15:0]  ext;
  logic [31:0]  pc;
  logic [31:0]  sp;
  logic [127:0] areg;
  logic         busy, pc_we, mdr_we, mem_we, mem_re;
  logic [31:0]  pc_new, mdr, waddr, raddr;
  logic [7:0]   wdata, rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] mem [256];

  always #2 clk = ~clk;

  branch_link_seq i_branch_link_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_i(op),
    .field_i(field), .ext_i(ext), .pc_i(pc), .sp_i(sp), .areg_i(areg),
    .busy_o(busy), .pc_we_o(pc_we), .pc_o(pc_new),
    .mdr_we_o(mdr_we), .mdr_o(mdr),
    .mem_we_o(mem_we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .mem_re_o(mem_re), .mem_raddr_o(raddr), .mem_rdata_i(rdata)
  );

  // byte memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[waddr[7:0]] <= wdata;
    if (mem_re) rdata <= mem[raddr[7:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] areg_of(input int n);
    return areg[32*n +: 32];
  endfunction

  task automatic issue(input logic [2:0] o, input logic [23:0] f, input logic [15:0] e,
                       input logic [31:0] p, input logic [31:0] s);
    @(negedge clk);
    start = 1'b1; op = o; field = f; ext = e; pc = p; sp = s;
    @(negedge clk);
    start = 1'b0; field = ~f; ext = ~e; pc = ~p; sp = ~s;
  endtask

  task automatic run_jump(input string tag, input logic [2:0] o, input logic [23:0] f,
                          input logic [15:0] e, input logic [31:0] p, input logic [31:0] exp);
    issue(o, f, e, p, 32'h0);
    chk({tag, " R8 busy"}, 32'(busy), 32'd1);
    chk({tag, " pc_we"}, 32'(pc_we), 32'd1);
    chk({tag, " target"}, pc_new, exp);
    chk({tag, " R5 no mdr on jump"}, 32'(mdr_we), 32'd0);
    @(negedge clk);
    chk({tag, " R8 idle"}, 32'(busy | pc_we), 32'd0);
  endtask

  task automatic run_call(input string tag, input logic [2:0] o, input logic [23:0] f,
                          input logic [15:0] e, input logic [31:0] p, input logic [31:0] s,
                          input logic [31:0] exp_t, input logic [31:0] exp_l, input bit inject);
    issue(o, f, e, p, s);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " R6 we"}, 32'(mem_we), 32'd1);
      chk({tag, " R6 waddr"}, waddr, s + 32'(k));
      chk({tag, " R6 wdata"}, 32'(wdata), 32'(exp_l[8*k +: 8]));
      chk({tag, " R8 busy"}, 32'(busy & ~pc_we), 32'd1);
      if (inject && k == 1) begin
        start = 1'b1; op = 3'd0; field = 24'h000002;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk({tag, " R6 pc_we after push"}, 32'(pc_we & ~mem_we), 32'd1);
    chk({tag, " R4 target"}, pc_new, exp_t);
    chk({tag, " R5 mdr_we"}, 32'(mdr_we), 32'd1);
    chk({tag, " R5 link"}, mdr, exp_l);
    @(negedge clk);
    chk({tag, " R8 idle"}, 32'(busy | pc_we | mdr_we | mem_we), 32'd0);
  endtask

  task automatic run_ret(input string tag, input logic [31:0] s, input logic [31:0] exp);
    issue(3'd6, 24'h0, 16'h0, 32'h0, s);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " R7 re"}, 32'(mem_re & ~mem_we), 32'd1);
      chk({tag, " R7 raddr"}, raddr, s + 32'(k));
      @(negedge clk);
    end
    chk({tag, " R7 drain"}, {30'd0, busy, pc_we | mem_re}, 32'd2);
    @(negedge clk);
    chk({tag, " R7 pc_we"}, 32'(pc_we), 32'd1);
    chk({tag, " R7 word"}, pc_new, exp);
    chk({tag, " R7 no mdr"}, 32'(mdr_we), 32'd0);
    @(negedge clk);
    chk({tag, " R8 idle"}, 32'(busy), 32'd0);
  endtask

  task automatic preload(input logic [31:0] s, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[8'(s + 32'(k))] = w[8*k +: 8];
  endtask

  initial begin
    logic [15:0] d16 [6] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
    logic [31:0] pcs [3] = '{32'h0000_0010, 32'h8000_0100, 32'hffff_fff0};
    logic [31:0] sps [3] = '{32'h0000_0040, 32'h0000_00fc, 32'hffff_fffe};
    rst_ni = 1'b0; start = 1'b0; op = 3'd0; field = '0; ext = '0; pc = '0; sp = '0;
    areg = {32'hffff_fffe, 32'h0000_0000, 32'h8123_4566, 32'h4000_1000};
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk("R11 reset strobes", {27'd0, busy, pc_we, mdr_we, mem_we, mem_re}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {27'd0, busy, pc_we, mdr_we, mem_we, mem_re}, 32'd0);

    // register forms: every selector, upper field bits set to noise
    for (int a = 0; a < 4; a++) begin
      run_jump("R1 jmp reg", 3'd0, 24'hfedcb4 | 24'(a), 16'hbeef, 32'h1234_5678, areg_of(a));
      run_call("R4 call reg", 3'd3, 24'h5a5a58 | 24'(a), 16'h0, pcs[a % 3], sps[a % 3],
               areg_of(a), pcs[a % 3] + 32'd2, 1'b0);
      run_ret("R7 ret after call reg", sps[a % 3], pcs[a % 3] + 32'd2);
    end

    // short relative forms around the sign boundary and address wrap
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 6; d++) begin
        run_jump("R2 jmp d16", 3'd1, {8'ha5, d16[d]}, 16'h0, pcs[p], pcs[p] + sx16(d16[d]));
        run_call("R4 call d16", 3'd4, {8'h3c, d16[d]}, 16'h0, pcs[p], sps[(p + d) % 3],
                 pcs[p] + sx16(d16[d]), pcs[p] + 32'd4, 1'b0);
        run_ret("R7 ret after call d16", sps[(p + d) % 3], pcs[p] + 32'd4);
      end
    end

    // long relative forms
    for (int p = 0; p < 3; p++) begin
      run_jump("R3 jmp d32", 3'd2, 24'h80_0001, 16'hff7f, pcs[p], pcs[p] + 32'h8000_017f);
      run_jump("R3 jmp d32 neg", 3'd2, 24'hff_ffff, 16'h00fc, pcs[p], pcs[p] + 32'hffff_fffc);
      run_call("R4 call d32", 3'd5, 24'h77_8001, 16'h2345, pcs[p], sps[p],
               pcs[p] + 32'h8001_2345, pcs[p] + 32'd6, 1'b0);
      run_ret("R7 ret after call d32", sps[p], pcs[p] + 32'd6);
    end

    // stand-alone returns with distinct byte patterns
    preload(32'h0000_0080, 32'hdead_beef);
    run_ret("R7 ret pattern", 32'h0000_0080, 32'hdead_beef);
    preload(32'hffff_fffd, 32'h0102_0304);
    run_ret("R7 ret wrap", 32'hffff_fffd, 32'h0102_0304);

    // request while busy
    run_call("R9 call ignores start", 3'd4, 24'h00_0100, 16'h0, 32'h0000_2000, 32'h0000_0020,
             32'h0000_2100, 32'h0000_2004, 1'b1);

    // unused code
    @(negedge clk);
    start = 1'b1; op = 3'd7; field = 24'h1; pc = 32'h55;
    @(negedge clk);
    start = 1'b0;
    chk("R10 unused code", {29'd0, busy, pc_we, mem_we | mem_re}, 32'd0);
    @(negedge clk);
    chk("R10 unused code later", {29'd0, busy, pc_we, mdr_we}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule